// File: doc/BRIEF.md
# Byte-Wide Host to Word-Wide ATA Data Bridge

This block lets an 8-bit host I/O bus reach the 16-bit data register of an ATA drive. Each drive data transfer moves a full word, so a single host byte access cannot carry it. The bridge splits and joins words with a one-byte holding register. A host read of the word address starts one drive read, returns the low half straight away and keeps the high half in the holding register. A later host read of the holding-register address returns that kept byte and does not touch the drive. Writes work the other way round. The host first writes the high byte into the holding register. A write to the word address then sends the joined word to the drive with a single write strobe.

A static mode input chooses which host address bit selects the holding register. In the default mode it is A0. A 16-bit port instruction that the bus splits into an even byte cycle and then an odd byte cycle therefore moves exactly one drive word. In legacy mode it is the top address bit, so the holding register sits eight ports above the word address. The remaining address bits drive the drive's register-select lines. Accesses to any drive register other than the data register pass through as plain byte cycles.

The block is fully synchronous. A host strobe is a one-cycle pulse. The drive strobe follows one cycle later. Read data returns with a one-cycle valid pulse two cycles after the request.

Top module: `ata_byte_bridge`

## Requirements
- R1: After reset, ata_rd, ata_wr, ata_dout_en and host_rvalid are low, and the holding register reads back as 8'h00.
- R2: In default mode (legacy_sel=0), a host read at address 0 drives ata_rd high for exactly the next cycle with ata_reg=0. Two cycles after the request, host_rvalid pulses with host_dout equal to ata_din[7:0] as sampled during the strobe cycle.
- R3: A host read of the holding address (address 1 in default mode) returns ata_din[15:8] of the most recent word read and produces no drive strobe.
- R4: A host write to the holding address stores host_din with no drive strobe. A following host write to address 0 drives ata_wr, and ata_dout_en, high for exactly the next cycle with ata_dout = {held byte, host_din} and ata_reg=0.
- R5: With legacy_sel=1 the holding register is at address 8 and the word access at address 0. Address 1 then becomes a plain access to drive register 1.
- R6: ata_reg equals host_addr[3:1] in default mode and host_addr[2:0] in legacy mode. An address whose register field is nonzero is a pass-through access whatever the value of the select bit.
- R7: A pass-through read produces one ata_rd pulse and returns ata_din[7:0]. The holding register is left unchanged.
- R8: A pass-through write produces one ata_wr pulse with ata_dout = {8'h00, host_din}. The holding register is left unchanged.
- R9: A read of the holding address with no word read before it returns the last stored value, including a byte staged by a host write, and starts no drive access.
- R10: Back-to-back host reads of address 0 and then address 1 return the low and then the high byte of one drive word, using a single ata_rd pulse.
- R11: ata_rd and ata_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_sel | input | 1 | 1: top address bit selects holding register; 0: A0 selects it |
| host_addr | input | 4 | Host port address within the bridge window |
| host_rd | input | 1 | One-cycle host read request |
| host_wr | input | 1 | One-cycle host write request (ignored when host_rd is high) |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_rvalid | output | 1 | host_dout valid pulse |
| ata_din | input | 16 | Data from drive |
| ata_dout | output | 16 | Data to drive |
| ata_dout_en | output | 1 | Drive data bus output enable |
| ata_rd | output | 1 | Drive read strobe |
| ata_wr | output | 1 | Drive write strobe |
| ata_reg | output | 3 | Drive register select |

## Verification
The embedded assertions check, on every cycle, that the two drive strobes are exclusive and that each word request is followed by the right strobe and register select. They also check that a held-byte access never strobes the drive, that the upper half of a written word is the byte held one cycle earlier, and that a pass-through read leaves the holding register stable. Only the bench scenarios can show end-to-end data values: which byte of a word returns at which address in each mode, the ordering of a split 16-bit transfer, and the value read back from the holding register after reset or after a staged write.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_WORD = 2'd1,
    ACC_HOLD = 2'd2,
    ACC_PASS = 2'd3
  } acc_kind_t;

  function automatic acc_kind_t kind_from(input logic reg_zero, input logic sel);
    if (!reg_zero) return ACC_PASS;
    return sel ? ACC_HOLD : ACC_WORD;
  endfunction

  function automatic logic [15:0] join_word(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/bridge_decode.sv
module bridge_decode
  import ata_bridge_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int REG_W = ADDR_W - 1
) (
  input  logic              legacy_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic [REG_W-1:0]  reg_sel,
  output acc_kind_t         kind
);
  logic sel_bit;

  always_comb begin
    if (legacy_sel) begin
      sel_bit = addr[ADDR_W-1];
      reg_sel = addr[ADDR_W-2:0];
    end else begin
      sel_bit = addr[0];
      reg_sel = addr[ADDR_W-1:1];
    end
    kind = kind_from(reg_sel == '0, sel_bit);
  end
endmodule

// File: rtl/bridge_hold.sv
module bridge_hold #(
  parameter int HOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_host,
  input  logic [HOST_W-1:0] host_byte,
  input  logic              ld_drive,
  input  logic [HOST_W-1:0] drive_byte,
  output logic [HOST_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        q <= '0;
    else if (ld_host)  q <= host_byte;
    else if (ld_drive) q <= drive_byte;
  end
endmodule

// File: rtl/bridge_drive.sv
module bridge_drive
  import ata_bridge_pkg::*;
#(
  parameter int HOST_W = 8,
  parameter int REG_W  = 3,
  localparam int ATA_W = 2 * HOST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  acc_kind_t         kind,
  input  logic [REG_W-1:0]  reg_sel,
  input  logic [HOST_W-1:0] wdata,
  input  logic [HOST_W-1:0] hold_byte,
  output logic              ata_rd,
  output logic              ata_wr,
  output logic [REG_W-1:0]  ata_reg,
  output logic [ATA_W-1:0]  ata_dout,
  output acc_kind_t         rd_kind
);
  logic drive_access;
  assign drive_access = (kind == ACC_WORD) || (kind == ACC_PASS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ata_rd   <= 1'b0;
      ata_wr   <= 1'b0;
      ata_reg  <= '0;
      ata_dout <= '0;
      rd_kind  <= ACC_IDLE;
    end else begin
      ata_rd  <= req_rd && drive_access;
      ata_wr  <= req_wr && drive_access;
      rd_kind <= req_rd ? kind : ACC_IDLE;
      if ((req_rd || req_wr) && drive_access) ata_reg <= reg_sel;
      if (req_wr && drive_access)
        ata_dout <= (kind == ACC_WORD) ? join_word(hold_byte, wdata)
                                       : join_word('0, wdata);
    end
  end

  assert_word_rd_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && kind == ACC_WORD) |=> (ata_rd && ata_reg == '0));

  assert_hold_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_rd || req_wr) && kind == ACC_HOLD) |=> (!ata_rd && !ata_wr));

  assert_wr_upper_is_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && kind == ACC_WORD) |=> (ata_wr && ata_dout[ATA_W-1:HOST_W] == $past(hold_byte)));

  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ata_rd && ata_wr));
endmodule

// File: rtl/bridge_return.sv
module bridge_return
  import ata_bridge_pkg::*;
#(
  parameter int HOST_W = 8,
  localparam int ATA_W = 2 * HOST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_t         rd_kind,
  input  logic [ATA_W-1:0]  ata_din,
  input  logic [HOST_W-1:0] hold_byte,
  output logic              cap_word,
  output logic [HOST_W-1:0] cap_hi,
  output logic [HOST_W-1:0] host_dout,
  output logic              host_rvalid
);
  assign cap_word = (rd_kind == ACC_WORD);
  assign cap_hi   = ata_din[ATA_W-1:HOST_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_dout   <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= (rd_kind != ACC_IDLE);
      if (rd_kind == ACC_HOLD)      host_dout <= hold_byte;
      else if (rd_kind != ACC_IDLE) host_dout <= ata_din[HOST_W-1:0];
    end
  end
endmodule

// File: rtl/ata_byte_bridge.sv
module ata_byte_bridge
  import ata_bridge_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int HOST_W = 8,
  localparam int REG_W = ADDR_W - 1,
  localparam int ATA_W = 2 * HOST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              legacy_sel,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [HOST_W-1:0] host_din,
  output logic [HOST_W-1:0] host_dout,
  output logic              host_rvalid,
  input  logic [ATA_W-1:0]  ata_din,
  output logic [ATA_W-1:0]  ata_dout,
  output logic              ata_dout_en,
  output logic              ata_rd,
  output logic              ata_wr,
  output logic [REG_W-1:0]  ata_reg
);
  logic [REG_W-1:0]  dec_reg;
  acc_kind_t         dec_kind;
  logic              req_rd, req_wr;
  acc_kind_t         rd_kind;
  logic [HOST_W-1:0] hold_q;
  logic              cap_word;
  logic [HOST_W-1:0] cap_hi;
  logic              hold_ld_host;

  assign req_rd       = host_rd;
  assign req_wr       = host_wr && !host_rd;
  assign hold_ld_host = req_wr && (dec_kind == ACC_HOLD);

  bridge_decode #(.ADDR_W(ADDR_W)) u_dec (
    .legacy_sel (legacy_sel),
    .addr       (host_addr),
    .reg_sel    (dec_reg),
    .kind       (dec_kind)
  );

  bridge_drive #(.HOST_W(HOST_W), .REG_W(REG_W)) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_rd    (req_rd),
    .req_wr    (req_wr),
    .kind      (dec_kind),
    .reg_sel   (dec_reg),
    .wdata     (host_din),
    .hold_byte (hold_q),
    .ata_rd    (ata_rd),
    .ata_wr    (ata_wr),
    .ata_reg   (ata_reg),
    .ata_dout  (ata_dout),
    .rd_kind   (rd_kind)
  );

  bridge_hold #(.HOST_W(HOST_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_host    (hold_ld_host),
    .host_byte  (host_din),
    .ld_drive   (cap_word),
    .drive_byte (cap_hi),
    .q          (hold_q)
  );

  bridge_return #(.HOST_W(HOST_W)) u_ret (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_kind     (rd_kind),
    .ata_din     (ata_din),
    .hold_byte   (hold_q),
    .cap_word    (cap_word),
    .cap_hi      (cap_hi),
    .host_dout   (host_dout),
    .host_rvalid (host_rvalid)
  );

  assign ata_dout_en = ata_wr;

  assert_rd_then_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ata_rd |=> host_rvalid);

  assert_pass_keeps_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_kind == ACC_PASS && !hold_ld_host) |=> $stable(hold_q));

  assert_pass_wr_keeps_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && dec_kind == ACC_PASS && !cap_word) |=> $stable(hold_q));
endmodule

// File: tb/ata_byte_bridge_test.sv
module ata_byte_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        legacy_sel = 1'b0;
  logic [3:0]  host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0]  host_din = '0;
  logic [7:0]  host_dout;
  logic        host_rvalid;
  logic [15:0] ata_din = '0;
  logic [15:0] ata_dout;
  logic        ata_dout_en, ata_rd, ata_wr;
  logic [2:0]  ata_reg;

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, both_cnt = 0, en_bad = 0;
  logic [2:0]  last_rd_reg = '0, last_wr_reg = '0;
  logic [15:0] last_wr_word = '0;

  always #10 clk = ~clk;

  ata_byte_bridge uut (.*);

  always @(posedge clk) begin
    if (ata_rd) begin rd_cnt++; last_rd_reg = ata_reg; end
    if (ata_wr) begin wr_cnt++; last_wr_reg = ata_reg; last_wr_word = ata_dout; end
    if (ata_rd && ata_wr) both_cnt++;
    if (ata_wr != ata_dout_en) en_bad++;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_read(input logic [3:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    @(negedge clk); d = host_dout; v = host_rvalid;
  endtask

  task automatic host_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_din = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_reset;
    logic [7:0] d; logic v;
    chk("R1 ata_rd", {15'd0, ata_rd}, 16'd0);
    chk("R1 ata_wr", {15'd0, ata_wr}, 16'd0);
    chk("R1 ata_dout_en", {15'd0, ata_dout_en}, 16'd0);
    chk("R1 host_rvalid", {15'd0, host_rvalid}, 16'd0);
    host_read(4'd1, d, v);
    chk("R1 hold after reset", {8'd0, d}, 16'h0000);
  endtask

  task automatic test_word_read;
    logic [7:0] d; logic v; int n0;
    ata_din = 16'hA55A; n0 = rd_cnt;
    host_read(4'd0, d, v);
    chk("R2 low byte", {8'd0, d}, 16'h005A);
    chk("R2 valid", {15'd0, v}, 16'd1);
    chk("R2 one strobe", 16'(rd_cnt - n0), 16'd1);
    chk("R2 reg", {13'd0, last_rd_reg}, 16'd0);
    ata_din = 16'h0000; n0 = rd_cnt;
    host_read(4'd1, d, v);
    chk("R3 high byte", {8'd0, d}, 16'h00A5);
    chk("R3 no strobe", 16'(rd_cnt - n0), 16'd0);
  endtask

  task automatic test_split_word;
    logic [7:0] lo, hi; int n0;
    ata_din = 16'h1234; n0 = rd_cnt;
    @(negedge clk); host_addr = 4'd0; host_rd = 1'b1;
    @(negedge clk); host_addr = 4'd1;
    @(negedge clk); host_rd = 1'b0; lo = host_dout;
    @(negedge clk); hi = host_dout;
    chk("R10 low", {8'd0, lo}, 16'h0034);
    chk("R10 high", {8'd0, hi}, 16'h0012);
    chk("R10 single strobe", 16'(rd_cnt - n0), 16'd1);
  endtask

  task automatic test_word_write;
    int n0; logic [7:0] d; logic v;
    n0 = wr_cnt;
    host_write(4'd1, 8'hC3);
    chk("R4 stage no strobe", 16'(wr_cnt - n0), 16'd0);
    host_write(4'd0, 8'h3C);
    chk("R4 one strobe", 16'(wr_cnt - n0), 16'd1);
    chk("R4 word", last_wr_word, 16'hC33C);
    chk("R4 reg", {13'd0, last_wr_reg}, 16'd0);
    n0 = rd_cnt;
    host_read(4'd1, d, v);
    chk("R9 staged byte", {8'd0, d}, 16'h00C3);
    chk("R9 no drive access", 16'(rd_cnt - n0), 16'd0);
  endtask

  task automatic test_pass;
    logic [7:0] d; logic v; int n0;
    ata_din = 16'hBEEF; n0 = rd_cnt;
    host_read(4'd5, d, v);
    chk("R7 pass data", {8'd0, d}, 16'h00EF);
    chk("R7 one strobe", 16'(rd_cnt - n0), 16'd1);
    chk("R6 reg from A3..A1", {13'd0, last_rd_reg}, 16'd2);
    host_read(4'd3, d, v);
    chk("R6 odd addr nonzero reg is pass", {13'd0, last_rd_reg}, 16'd1);
    host_read(4'd1, d, v);
    chk("R7 hold unchanged", {8'd0, d}, 16'h00C3);
    host_write(4'd7, 8'h77);
    chk("R8 pass word", last_wr_word, 16'h0077);
    chk("R8 pass reg", {13'd0, last_wr_reg}, 16'd3);
    host_read(4'd1, d, v);
    chk("R8 hold unchanged", {8'd0, d}, 16'h00C3);
  endtask

  task automatic test_legacy;
    logic [7:0] d; logic v; int n0;
    legacy_sel = 1'b1;
    ata_din = 16'h9876;
    host_read(4'd0, d, v);
    chk("R5 low", {8'd0, d}, 16'h0076);
    ata_din = 16'h4321; n0 = rd_cnt;
    host_read(4'd8, d, v);
    chk("R5 hold at 8", {8'd0, d}, 16'h0098);
    chk("R5 hold no strobe", 16'(rd_cnt - n0), 16'd0);
    host_read(4'd1, d, v);
    chk("R5 addr1 is pass", {8'd0, d}, 16'h0021);
    chk("R6 legacy reg", {13'd0, last_rd_reg}, 16'd1);
    host_read(4'd8, d, v);
    chk("R5 hold kept", {8'd0, d}, 16'h0098);
    legacy_sel = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset;
    test_word_read;
    test_split_word;
    test_word_write;
    test_pass;
    test_legacy;
    chk("R11 strobes exclusive", 16'(both_cnt), 16'd0);
    chk("R4 dout_en tracks write", 16'(en_bad), 16'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule